// File: doc/BRIEF.md
# Multiplied Clock Correction Counter

This block keeps the number of multiplied-clock ticks in step with the number of input edges. Each input edge is reported by a one-cycle strobe. On each edge, a 16-bit edge counter is sampled, multiplied by a power of two from 32 to 256, and stored as the tick target. The edge counter then advances by one. A 16-bit tick counter advances on each multiplied-clock tick strobe.

When correction mode is on, the tick counter stops once it equals the target. It starts again only after a later edge has raised the target. If the input slows down, the multiplied clock therefore cannot run ahead of the edges: over any one input period, the tick counter gains no more than the multiplication factor. When correction mode is off, the tick counter runs freely.

A synchronous clear input returns all three counters to zero. It is meant for software writes and a counter-clear control.

Top module: `mult_tick_corrector`

## Requirements
- R1: After reset, the edge counter, the target and the tick counter all read zero.
- R2: When an edge strobe arrives, the target takes the edge counter's value before the edge, shifted left and truncated to 16 bits. The edge counter increments by one and wraps modulo 2^16. Both are visible one cycle after the strobe.
- R3: The 2-bit scale select gives the shift on an edge. Code 0 selects a shift of 5 (x32), code 1 a shift of 6 (x64), code 2 a shift of 7 (x128) and code 3 a shift of 8 (x256).
- R4: With correction mode low, every tick strobe increments the tick counter by one, modulo 2^16, whatever the target.
- R5: With correction mode high, a tick strobe leaves the tick counter unchanged if it equals the target. Otherwise the tick strobe increments the tick counter.
- R6: A halted tick counter resumes counting on ticks after an edge has loaded a larger target. It halts again at the new target.
- R7: When an edge and a tick arrive in the same cycle, the tick is compared against the target being loaded by that edge, not the old one.
- R8: A clear input zeroes all three counters on the next cycle. Clear takes priority over an edge or tick in the same cycle.
- R9: In a cycle with no edge, no tick and no clear, all three counters keep their values. A change of the scale select alone does not alter the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all counters |
| edge_i | input | 1 | Captured input edge strobe |
| tick_i | input | 1 | Multiplied-clock tick strobe |
| scale_sel_i | input | 2 | Multiplier select: 0=x32, 1=x64, 2=x128, 3=x256 |
| hold_en_i | input | 1 | Correction mode: halt ticks at the target |
| edge_cnt_o | output | 16 | Edge counter |
| target_o | output | 16 | Scaled tick target |
| tick_cnt_o | output | 16 | Tick counter |

## Verification
The bench builds the block with its default parameters: a 16-bit counter width and a base shift of 5.

With these values, 65,539 tick strobes are enough to wrap the tick counter. It takes 257 edges at scale code 3 to push the scaled edge count past 16 bits and truncate the target to zero. Both boundaries therefore fall within a short directed run.

The x32 minimum also means a halt-and-resume sequence needs only a few dozen ticks. The same-cycle edge-and-tick ordering can then be observed at a halted counter.

// File: rtl/mult_tick_corrector.sv
module mult_tick_corrector #(
  parameter int CNT_W      = 16,
  parameter int SHIFT_BASE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic [1:0]       scale_sel_i,
  input  logic             hold_en_i,
  output logic [CNT_W-1:0] edge_cnt_o,
  output logic [CNT_W-1:0] target_o,
  output logic [CNT_W-1:0] tick_cnt_o
);

  localparam int SH_W = $clog2(SHIFT_BASE + 4) + 1;

  logic [CNT_W-1:0] edge_q, target_q, tick_q;
  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] cmp_target;
  logic             at_limit;
  logic             tick_adv;

  assign shamt      = SH_W'(SHIFT_BASE) + SH_W'(scale_sel_i);
  assign scaled     = edge_q << shamt;
  assign cmp_target = edge_i ? scaled : target_q;
  assign at_limit   = hold_en_i && (tick_q == cmp_target);
  assign tick_adv   = tick_i && !at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= '0;
      target_q <= '0;
      tick_q   <= '0;
    end else if (clear_i) begin
      edge_q   <= '0;
      target_q <= '0;
      tick_q   <= '0;
    end else begin
      if (edge_i) begin
        target_q <= scaled;
        edge_q   <= edge_q + 1'b1;
      end
      if (tick_adv) tick_q <= tick_q + 1'b1;
    end
  end

  assign edge_cnt_o = edge_q;
  assign target_o   = target_q;
  assign tick_cnt_o = tick_q;

endmodule

module mult_tick_corrector_chk #(
  parameter int CNT_W      = 16,
  parameter int SHIFT_BASE = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             edge_i,
  input logic             tick_i,
  input logic [1:0]       scale_sel_i,
  input logic             hold_en_i,
  input logic [CNT_W-1:0] edge_cnt_o,
  input logic [CNT_W-1:0] target_o,
  input logic [CNT_W-1:0] tick_cnt_o
);

  logic [CNT_W-1:0] exp_target;
  assign exp_target = CNT_W'({{CNT_W{1'b0}}, edge_cnt_o} << (SHIFT_BASE + int'(scale_sel_i)));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (edge_cnt_o == '0 && target_o == '0 && tick_cnt_o == '0));

  assert_edge_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !clear_i) |=> edge_cnt_o == CNT_W'($past(edge_cnt_o) + 1'b1));

  assert_target_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !clear_i) |=> target_o == $past(exp_target));

  assert_free_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_en_i && !clear_i) |=> tick_cnt_o == CNT_W'($past(tick_cnt_o) + 1'b1));

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && hold_en_i && !edge_i && !clear_i && tick_cnt_o == target_o) |=> $stable(tick_cnt_o));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !edge_i && !clear_i) |=>
      ($stable(tick_cnt_o) && $stable(edge_cnt_o) && $stable(target_o)));

endmodule

bind mult_tick_corrector mult_tick_corrector_chk #(.CNT_W(CNT_W), .SHIFT_BASE(SHIFT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .edge_i(edge_i), .tick_i(tick_i),
  .scale_sel_i(scale_sel_i), .hold_en_i(hold_en_i), .edge_cnt_o(edge_cnt_o),
  .target_o(target_o), .tick_cnt_o(tick_cnt_o)
);

// File: tb/test_mult_tick_corrector.sv
module test_mult_tick_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0, edge_i = 1'b0, tick_i = 1'b0, hold_en_i = 1'b0;
  logic [1:0]  scale_sel_i = 2'd0;
  logic [15:0] edge_cnt_o, target_o, tick_cnt_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mult_tick_corrector i_mult_tick_corrector (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .edge_i(edge_i), .tick_i(tick_i),
    .scale_sel_i(scale_sel_i), .hold_en_i(hold_en_i), .edge_cnt_o(edge_cnt_o),
    .target_o(target_o), .tick_cnt_o(tick_cnt_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic e, input logic t);
    clear_i = c; edge_i = e; tick_i = t;
    @(negedge clk);
    clear_i = 1'b0; edge_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1", "edge count", edge_cnt_o, 16'd0);
    chk("R1", "target", target_o, 16'd0);
    chk("R1", "tick count", tick_cnt_o, 16'd0);
  endtask

  task automatic t_scale;
    for (int s = 0; s < 4; s++) begin
      scale_sel_i = 2'(s);
      cyc(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0);
      chk("R2", "edge count after 3 edges", edge_cnt_o, 16'd3);
      chk("R3", "target for scale code", target_o, 16'(2 << (5 + s)));
    end
    scale_sel_i = 2'd3;
    cyc(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 256; k++) cyc(1'b0, 1'b1, 1'b0);
    chk("R2", "target before truncation", target_o, 16'(255 << 8));
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2", "target truncated to 16 bits", target_o, 16'd0);
    chk("R2", "edge count 257", edge_cnt_o, 16'd257);
  endtask

  task automatic t_free;
    hold_en_i = 1'b0;
    cyc(1'b1, 1'b0, 1'b0);
    ticks(10);
    chk("R4", "free ticks past target", tick_cnt_o, 16'd10);
    ticks(65536 - 10 + 3);
    chk("R4", "tick count wraps", tick_cnt_o, 16'd3);
  endtask

  task automatic t_hold;
    hold_en_i = 1'b1; scale_sel_i = 2'd0;
    cyc(1'b1, 1'b0, 1'b0);
    ticks(5);
    chk("R5", "halted at zero target", tick_cnt_o, 16'd0);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(3);
    chk("R5", "still halted after first edge", tick_cnt_o, 16'd0);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R6", "target raised", target_o, 16'd32);
    ticks(40);
    chk("R6", "resumed and halted at 32", tick_cnt_o, 16'd32);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(40);
    chk("R6", "halted at 64", tick_cnt_o, 16'd64);
    hold_en_i = 1'b0;
  endtask

  task automatic t_same;
    hold_en_i = 1'b1; scale_sel_i = 2'd0;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(35);
    chk("R7", "halted before joint event", tick_cnt_o, 16'd32);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R7", "tick passes under new target", tick_cnt_o, 16'd33);
    chk("R7", "new target", target_o, 16'd64);
    hold_en_i = 1'b0;
  endtask

  task automatic t_clear;
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R8", "edge count cleared", edge_cnt_o, 16'd0);
    chk("R8", "target cleared", target_o, 16'd0);
    chk("R8", "tick count cleared", tick_cnt_o, 16'd0);
  endtask

  task automatic t_idle;
    scale_sel_i = 2'd0;
    cyc(1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(4);
    scale_sel_i = 2'd3;
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b0);
    chk("R9", "target unchanged by select", target_o, 16'd32);
    chk("R9", "edge count held", edge_cnt_o, 16'd2);
    chk("R9", "tick count held", tick_cnt_o, 16'd4);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_scale;
    t_free;
    t_hold;
    t_same;
    t_clear;
    t_idle;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule